// File: doc/BRIEF.md
# Per-core line interrupt status unit

This block gathers the thirteen level-sensitive, active-high interrupt lines of one processor core into a registered status vector. It masks that vector with a locally held enable mask, and reports a single registered pending request together with the number of the highest pending, enabled line. The number of a line is its bit position in the status vector.

The bits do not all behave alike. Every status bit has its own source and its own rule for being cleared:

- The eight hardware lines and the inter-core line come from outside the core. Each passes a two-flop synchronizer and then follows its input level without latching.
- The timer bit is set by a one-cycle expiry pulse. It holds until software writes a one to a separate clear register.
- The overflow bit is live while any performance counter with its interrupt enabled has its top bit set.
- The two software bits are the only ones a status write can change.

A narrow register write port reaches three locations: the status register, the enable mask and the timer-clear register.

Top module: `line_irq_status`

## Requirements
- R1: During and after synchronous reset, `status`, `irq_pending` and `irq_num` are all zero. The enable mask is also reset to zero.
- R2: The status layout is fixed:
  - bits 1:0 are the software lines;
  - bit 2+i is `hwi_in[i]` (bits 9:2 for eight lines);
  - bit 10 is counter overflow;
  - bit 11 is timer;
  - bit 12 is inter-core.

  The interrupt number reported for a line equals its bit index.
- R3: A change on `hwi_in[i]` or `ipi_in` appears on its status bit exactly three rising edges after the input changes. The bit falls the same way when the input falls, with no latching.
- R4: A write with `csr_addr`=0 loads `csr_wdata[1:0]` into status bits 1:0 at the next edge. A one sets a bit and a zero clears it. Bits 12:2 of the written value are ignored.
- R5: A `timer_pulse` sets status bit 11 at the next edge. The bit then holds until a write with `csr_addr`=2 and `csr_wdata[0]`=1. A write to address 2 with bit 0 at zero has no effect. A pulse in the same cycle as a clear leaves the bit set.
- R6: Status bit 10 equals the OR over counters of `pmc_ovf[k] & pmc_ie[k]`, registered one edge. It drops when either the overflow flag or the enable is removed.
- R7: A write with `csr_addr`=1 loads the 13-bit enable mask at the next edge. A status bit whose mask bit is 0 never makes `irq_pending` high and never appears as `irq_num`.
- R8: `irq_num` is the highest index set in (status AND mask), registered one edge after status. It is 0 when no enabled bit is set.
- R9: `irq_pending` is high exactly when `global_ie` and at least one bit of (status AND mask) are both high. It is registered, one edge after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ipi_in | input | 1 | Inter-core interrupt level, asynchronous |
| hwi_in | input | NUM_HWI | External hardware interrupt levels, asynchronous |
| timer_pulse | input | 1 | One-cycle countdown expiry pulse |
| pmc_ovf | input | NUM_PMC | Top bit of each performance counter |
| pmc_ie | input | NUM_PMC | Interrupt enable of each performance counter |
| global_ie | input | 1 | Global interrupt enable |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 status, 1 mask, 2 timer clear |
| csr_wdata | input | LINES | Write data |
| status | output | LINES | Registered status vector |
| irq_pending | output | 1 | Registered pending request |
| irq_num | output | NUMW | Registered number of highest pending enabled line |

## Verification
On every cycle, the assertions check the following:
- software bits follow their writes;
- the timer bit sets on a pulse and otherwise keeps its value unless a clear arrives;
- the overflow bit tracks the enabled overflow flags one edge late;
- a raised pending request always had global enable and an enabled status bit behind it;
- the reported number pointed at a set bit.

Only the bench scenarios show the exact three-edge latency of the synchronized lines, the pulse-beats-clear ordering, the bits ignored on a status write, and the highest-index choice under random mixes of lines and masks.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  // register selects on the write port
  typedef enum logic [1:0] {
    CSR_STAT = 2'd0,
    CSR_MASK = 2'd1,
    CSR_TCLR = 2'd2,
    CSR_NONE = 2'd3
  } csr_sel_e;

  localparam int SWI_LINES = 2;
  localparam int HWI_LO    = SWI_LINES;

  function automatic int pmc_bit(input int nhwi);
    return HWI_LO + nhwi;
  endfunction

  function automatic int line_count(input int nhwi);
    return HWI_LO + nhwi + 3;
  endfunction
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lirq_status.sv
module lirq_status #(
  parameter int NUM_HWI = 8,
  parameter int LINES   = lirq_pkg::line_count(NUM_HWI)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_HWI-1:0] hwi_s,
  input  logic               ipi_s,
  input  logic               timer_pulse,
  input  logic               pmc_any,
  input  logic               swi_we,
  input  logic [1:0]         swi_wdata,
  input  logic               tclr,
  output logic [LINES-1:0]   status
);
  localparam int PMC_B = lirq_pkg::pmc_bit(NUM_HWI);
  localparam int TMR_B = PMC_B + 1;
  localparam int IPI_B = PMC_B + 2;

  // software lines: only writable bits
  always_ff @(posedge clk) begin
    if (rst)         status[1:0] <= '0;
    else if (swi_we) status[1:0] <= swi_wdata;
  end

  // hardware lines follow synchronized levels
  for (genvar i = 0; i < NUM_HWI; i++) begin : g_hwi
    always_ff @(posedge clk) begin
      if (rst) status[lirq_pkg::HWI_LO+i] <= 1'b0;
      else     status[lirq_pkg::HWI_LO+i] <= hwi_s[i];
    end
  end

  // overflow level, timer latch (set beats clear), inter-core level
  always_ff @(posedge clk) begin
    if (rst) begin
      status[PMC_B] <= 1'b0;
      status[TMR_B] <= 1'b0;
      status[IPI_B] <= 1'b0;
    end else begin
      status[PMC_B] <= pmc_any;
      if (timer_pulse)  status[TMR_B] <= 1'b1;
      else if (tclr)    status[TMR_B] <= 1'b0;
      status[IPI_B] <= ipi_s;
    end
  end
endmodule

// File: rtl/lirq_prio.sv
module lirq_prio #(
  parameter int LINES = 13,
  parameter int NUMW  = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] active,
  input  logic             gie,
  output logic             pending,
  output logic [NUMW-1:0]  num
);
  logic [NUMW-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < LINES; i++) begin
      if (active[i]) best = NUMW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      num     <= '0;
    end else begin
      pending <= gie & (|active);
      num     <= best;
    end
  end
endmodule

// File: rtl/line_irq_status.sv
module line_irq_status #(
  parameter int NUM_HWI     = 8,
  parameter int NUM_PMC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LINES       = lirq_pkg::line_count(NUM_HWI),
  parameter int NUMW        = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ipi_in,
  input  logic [NUM_HWI-1:0] hwi_in,
  input  logic               timer_pulse,
  input  logic [NUM_PMC-1:0] pmc_ovf,
  input  logic [NUM_PMC-1:0] pmc_ie,
  input  logic               global_ie,
  input  logic               csr_we,
  input  logic [1:0]         csr_addr,
  input  logic [LINES-1:0]   csr_wdata,
  output logic [LINES-1:0]   status,
  output logic               irq_pending,
  output logic [NUMW-1:0]    irq_num
);
  import lirq_pkg::*;

  logic [NUM_HWI:0] ext_raw, ext_s;
  logic             swi_we, mask_we, tclr, pmc_any;
  logic [LINES-1:0] mask_q;

  assign ext_raw = {ipi_in, hwi_in};

  lirq_sync #(.W(NUM_HWI+1), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(ext_raw), .q(ext_s)
  );

  assign swi_we  = csr_we && (csr_addr == CSR_STAT);
  assign mask_we = csr_we && (csr_addr == CSR_MASK);
  assign tclr    = csr_we && (csr_addr == CSR_TCLR) && csr_wdata[0];
  assign pmc_any = |(pmc_ovf & pmc_ie);

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= csr_wdata;
  end

  lirq_status #(.NUM_HWI(NUM_HWI), .LINES(LINES)) stat_i (
    .clk(clk), .rst(rst),
    .hwi_s(ext_s[NUM_HWI-1:0]), .ipi_s(ext_s[NUM_HWI]),
    .timer_pulse(timer_pulse), .pmc_any(pmc_any),
    .swi_we(swi_we), .swi_wdata(csr_wdata[1:0]), .tclr(tclr),
    .status(status)
  );

  lirq_prio #(.LINES(LINES), .NUMW(NUMW)) prio_i (
    .clk(clk), .rst(rst), .active(status & mask_q), .gie(global_ie),
    .pending(irq_pending), .num(irq_num)
  );
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker #(
  parameter int NUM_HWI = 8,
  parameter int NUM_PMC = 4,
  parameter int LINES   = 13,
  parameter int NUMW    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               timer_pulse,
  input logic [NUM_PMC-1:0] pmc_ovf,
  input logic [NUM_PMC-1:0] pmc_ie,
  input logic               global_ie,
  input logic               csr_we,
  input logic [1:0]         csr_addr,
  input logic [LINES-1:0]   csr_wdata,
  input logic [LINES-1:0]   status,
  input logic               irq_pending,
  input logic [NUMW-1:0]    irq_num
);
  localparam int PMC_B = lirq_pkg::pmc_bit(NUM_HWI);
  localparam int TMR_B = PMC_B + 1;

  logic clr_now;
  assign clr_now = csr_we && (csr_addr == 2'd2) && csr_wdata[0];

  a_r4_swi_write: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_addr == 2'd0) |=> (status[1:0] == $past(csr_wdata[1:0])));

  a_r4_swi_hold: assert property (@(posedge clk) disable iff (rst)
    !(csr_we && csr_addr == 2'd0) |=> $stable(status[1:0]));

  a_r5_timer_set: assert property (@(posedge clk) disable iff (rst)
    timer_pulse |=> status[TMR_B]);

  a_r5_timer_hold: assert property (@(posedge clk) disable iff (rst)
    (!timer_pulse && !clr_now) |=> $stable(status[TMR_B]));

  a_r6_overflow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[PMC_B] == $past(|(pmc_ovf & pmc_ie))));

  a_r9_gate: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> $past(global_ie));

  a_r9_needs_status: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> ($past(status) != '0));

  a_r8_num_points_set: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> ((($past(status) >> irq_num) & 1) == 1));

  a_r8_num_range: assert property (@(posedge clk) disable iff (rst)
    32'(irq_num) < LINES);
endmodule

bind line_irq_status lirq_checker #(
  .NUM_HWI(NUM_HWI), .NUM_PMC(NUM_PMC), .LINES(LINES), .NUMW(NUMW)
) chk_i (
  .clk(clk), .rst(rst), .timer_pulse(timer_pulse), .pmc_ovf(pmc_ovf),
  .pmc_ie(pmc_ie), .global_ie(global_ie), .csr_we(csr_we),
  .csr_addr(csr_addr), .csr_wdata(csr_wdata), .status(status),
  .irq_pending(irq_pending), .irq_num(irq_num)
);

// File: tb/line_irq_status_tb_top.sv
`timescale 1ns/1ps
module line_irq_status_tb_top;
  localparam int NH = 8, NP = 4, L = 13, NW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ipi_in = 0, timer_pulse = 0, global_ie = 0, csr_we = 0;
  logic [NH-1:0] hwi_in = '0;
  logic [NP-1:0] pmc_ovf = '0, pmc_ie = '0;
  logic [1:0]    csr_addr = '0;
  logic [L-1:0]  csr_wdata = '0;
  logic [L-1:0]  status;
  logic          irq_pending;
  logic [NW-1:0] irq_num;

  int tests = 0, fails = 0;
  logic [L-1:0] mask_m;
  logic [1:0]   swi_m;
  logic         tmr_m;

  always #2.5 clk = ~clk;

  line_irq_status dut_i (
    .clk(clk), .rst(rst), .ipi_in(ipi_in), .hwi_in(hwi_in),
    .timer_pulse(timer_pulse), .pmc_ovf(pmc_ovf), .pmc_ie(pmc_ie),
    .global_ie(global_ie), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .status(status), .irq_pending(irq_pending),
    .irq_num(irq_num)
  );

  function automatic logic [NW-1:0] top_idx(input logic [L-1:0] v);
    logic [NW-1:0] r = '0;
    for (int i = 0; i < L; i++) if (v[i]) r = NW'(i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [L-1:0] d);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    step(1);
    csr_we = 0; csr_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    hwi_in = '1; ipi_in = 1; pmc_ovf = '1; pmc_ie = '1; global_ie = 1;
    step(4);
    chk("R1 status in reset", 32'(status), 0);
    chk("R1 pending in reset", 32'(irq_pending), 0);
    chk("R1 num in reset", 32'(irq_num), 0);
    hwi_in = '0; ipi_in = 0; pmc_ovf = '0; pmc_ie = '0; global_ie = 0;
    step(4);
    rst = 0;
    step(4);
    chk("R1 status after reset", 32'(status), 0);

    // R3 latency of hwi line 3 -> bit 5
    wr(2'd1, '1); global_ie = 1;
    hwi_in[3] = 1;
    step(2);
    chk("R3 hwi not yet after 2 edges", 32'(status[5]), 0);
    step(1);
    chk("R3 R2 hwi3 on bit5 after 3 edges", 32'(status), 32'h20);
    step(1);
    chk("R8 num is 5", 32'(irq_num), 5);
    chk("R9 pending", 32'(irq_pending), 1);
    hwi_in[3] = 0;
    step(2);
    chk("R3 still high before 3 edges", 32'(status[5]), 1);
    step(1);
    chk("R3 level follows, no latch", 32'(status), 0);

    // R3 inter-core on bit 12
    ipi_in = 1; step(3);
    chk("R3 R2 ipi on bit12", 32'(status), 32'h1000);
    step(1);
    chk("R8 R2 ipi number 12", 32'(irq_num), 12);
    ipi_in = 0; step(4);

    // R4 software write, upper bits ignored
    wr(2'd0, 13'h1FFE);
    chk("R4 swi1 set, upper ignored", 32'(status), 32'h2);
    wr(2'd0, 13'h0001);
    chk("R4 swi0 set swi1 cleared", 32'(status), 32'h1);
    wr(2'd0, 13'h0000);
    chk("R4 swi cleared by zero", 32'(status), 0);

    // R5 timer
    timer_pulse = 1; step(1); timer_pulse = 0;
    chk("R5 timer set by pulse", 32'(status), 32'h800);
    step(5);
    chk("R5 timer latched", 32'(status[11]), 1);
    wr(2'd2, 13'h1FFE);
    chk("R5 clear with bit0 zero ignored", 32'(status[11]), 1);
    timer_pulse = 1; wr(2'd2, 13'h1); timer_pulse = 0;
    chk("R5 pulse beats clear", 32'(status[11]), 1);
    wr(2'd2, 13'h1);
    chk("R5 cleared by write one", 32'(status[11]), 0);

    // R6 overflow
    pmc_ovf = 4'b0100; pmc_ie = 4'b1011; step(1);
    chk("R6 ovf without enable", 32'(status[10]), 0);
    pmc_ie = 4'b0100; step(1);
    chk("R6 ovf with enable", 32'(status), 32'h400);
    pmc_ie = 4'b0000; step(1);
    chk("R6 drop on enable removed", 32'(status[10]), 0);
    pmc_ie = 4'b0100; step(1); pmc_ovf = 4'b0000; step(1);
    chk("R6 drop on bit cleared", 32'(status[10]), 0);

    // R7 mask, R8 priority, R9 global enable
    wr(2'd0, 13'h3); hwi_in = 8'h81; step(4);
    chk("R8 highest among 9,2,1,0", 32'(irq_num), 9);
    wr(2'd1, 13'h1FFF & ~13'h200); step(1);
    chk("R7 masked bit9 skipped", 32'(irq_num), 2);
    wr(2'd1, 13'h0); step(1);
    chk("R7 all masked no pending", 32'(irq_pending), 0);
    chk("R8 none enabled num zero", 32'(irq_num), 0);
    wr(2'd1, 13'h1); global_ie = 0; step(1);
    chk("R9 global off gates", 32'(irq_pending), 0);
    global_ie = 1; step(1);
    chk("R9 global on", 32'(irq_pending), 1);
    chk("R8 swi0 number 0", 32'(irq_num), 0);

    // random mix
    mask_m = 13'h1; swi_m = 2'b11; tmr_m = 0;
    for (int it = 0; it < 60; it++) begin
      logic [L-1:0] es, ea;
      hwi_in = NH'($urandom); ipi_in = 1'($urandom);
      pmc_ovf = NP'($urandom); pmc_ie = NP'($urandom);
      global_ie = ($urandom % 4) != 0;
      if ($urandom % 2) begin mask_m = L'($urandom); wr(2'd1, mask_m); end
      if ($urandom % 2) begin
        logic [L-1:0] d = L'($urandom);
        swi_m = d[1:0]; wr(2'd0, d);
      end
      if ($urandom % 5 == 0) begin timer_pulse = 1; step(1); timer_pulse = 0; tmr_m = 1; end
      else if ($urandom % 5 == 0) begin wr(2'd2, 13'h1); tmr_m = 0; end
      step(5);
      es = {ipi_in, tmr_m, |(pmc_ovf & pmc_ie), hwi_in, swi_m};
      ea = es & mask_m;
      chk("R2 R3 R6 random status", 32'(status), 32'(es));
      chk("R9 R7 random pending", 32'(irq_pending), 32'(global_ie & (|ea)));
      chk("R8 random number", 32'(irq_num), 32'(top_idx(ea)));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule